// File: doc/BRIEF.md
# State Diagonal Fault Classifier

This block takes two 128-bit cipher states that were captured at the same point of a computation. One is a clean reference copy and the other may have been disturbed by an injection attempt. The block works out which of the four wrapped diagonals of the 4x4 byte grid hold at least one differing byte. It then sorts the sample by how many diagonals are affected. Where a faulty byte sits, and how many bytes are faulty, do not change the class.

A sampling strobe marks each attempt. The block registers the diagonal mask and the class code, and it keeps one event counter per class plus a running sample total. A programmable run length closes a measurement run: once it is reached, further samples are still classified but are no longer counted. A synchronous clear starts a new run.

Top module: `diag_fault_classifier`

## Requirements
- R1: Byte (row r, column c) occupies bits [8*(4c+r)+7 : 8*(4c+r)] of each state. Bit i of `diag_mask` is 1 exactly when some byte at (r, (r+i) mod 4), r = 0..3, differs between the two states.
- R2: `fault_class` equals the number of set bits in `diag_mask`. Code 0 = no fault, 1 = one diagonal, 2 = two, 3 = three, 4 = all four.
- R3: Mask and class register on the clock edge that samples `sample_valid`, and `result_valid` is high for exactly the following cycle. Without a sample, mask and class hold their last values.
- R4: After reset, `result_valid`, `diag_mask`, `fault_class`, every class counter, `sample_total` and `run_done` are all 0.
- R5: Each counted sample adds 1 to the counter of its class, at bits [10k+9 : 10k] of `class_counts` for class k, and adds 1 to `sample_total`.
- R6: With a nonzero `run_len`, `run_done` is 1 while `sample_total` >= `run_len`. Samples taken while `run_done` is 1 are classified but leave the counters and the total unchanged.
- R7: With `run_len` = 0 the run never closes and `run_done` stays 0. The counters and the total saturate at 1023 instead of wrapping.
- R8: `clear` zeroes all counters and the total on the next edge and wins over a sample in the same cycle. That sample is still classified; `clear` does not alter mask or class.
- R9: A difference confined to three or fewer bytes never yields class 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_valid | input | 1 | Both states are valid this cycle |
| ref_state | input | 128 | Fault-free reference state |
| obs_state | input | 128 | Observed, possibly corrupted state |
| clear | input | 1 | Synchronous clear of counters and total |
| run_len | input | 10 | Samples per run; 0 means unbounded |
| result_valid | output | 1 | Mask and class were updated on the last edge |
| diag_mask | output | 4 | One bit per faulty diagonal |
| fault_class | output | 3 | Class code 0..4 |
| class_counts | output | 50 | Five 10-bit class counters, class 0 in the low bits |
| sample_total | output | 10 | Samples counted in this run |
| run_done | output | 1 | Run length reached |

## Verification
The assertions assume that `run_len` changes only together with `clear`, or while the total is below both its old and new values. The check that the class counters sum to the total also assumes no counter has saturated. The stimulus follows this: every change of run length comes with a clear, and the saturating phase runs last with a zero run length, which turns off the sum check. The state inputs are arbitrary, so the checks on byte-count limits and equal-state samples hold for any data the bench applies.

// File: rtl/dfc_pkg.sv
package dfc_pkg;
  localparam int GRID_DIM    = 4;
  localparam int NUM_CLASSES = GRID_DIM + 1;
  localparam int CLASS_W     = $clog2(NUM_CLASSES);
  localparam int CNT_WIDTH   = 10;

  typedef logic [CLASS_W-1:0] class_t;

  localparam class_t CLS_CLEAN = class_t'(0);
endpackage

// File: rtl/dfc_diag_detect.sv
module dfc_diag_detect #(
  parameter int GRID = 4
) (
  input  logic [8*GRID*GRID-1:0] ref_state,
  input  logic [8*GRID*GRID-1:0] obs_state,
  output logic [GRID-1:0]        diag_mask
);
  logic [GRID-1:0][GRID-1:0] byte_hit;

  for (genvar d = 0; d < GRID; d++) begin : g_diag
    for (genvar r = 0; r < GRID; r++) begin : g_row
      localparam int COL = (r + d) % GRID;
      localparam int LSB = 8 * (GRID * COL + r);
      assign byte_hit[d][r] = |(ref_state[LSB +: 8] ^ obs_state[LSB +: 8]);
    end
    assign diag_mask[d] = |byte_hit[d];
  end
endmodule

// File: rtl/dfc_class_encode.sv
module dfc_class_encode #(
  parameter int GRID    = 4,
  parameter int CLASS_W = 3
) (
  input  logic [GRID-1:0]    diag_mask,
  output logic [CLASS_W-1:0] fault_class
);
  always_comb begin
    fault_class = '0;
    for (int i = 0; i < GRID; i++) begin
      fault_class = fault_class + CLASS_W'(diag_mask[i]);
    end
  end
endmodule

// File: rtl/dfc_event_counters.sv
module dfc_event_counters #(
  parameter int NUM_CLASSES = 5,
  parameter int CLASS_W     = 3,
  parameter int CNT_W       = 10
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         clear,
  input  logic                         sample_valid,
  input  logic [CLASS_W-1:0]           sample_class,
  input  logic [CNT_W-1:0]             run_len,
  output logic [NUM_CLASSES*CNT_W-1:0] class_counts,
  output logic [CNT_W-1:0]             sample_total,
  output logic                         run_done
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] total_q;
  logic             limit_on;
  logic             run_closed;
  logic             accept;

  assign limit_on   = (run_len != '0);
  assign run_closed = limit_on && (total_q >= run_len);
  assign accept     = sample_valid && !clear && !run_closed;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      total_q <= '0;
    end else if (accept && total_q != CNT_MAX) begin
      total_q <= total_q + 1'b1;
    end
  end

  for (genvar k = 0; k < NUM_CLASSES; k++) begin : g_cls
    logic [CNT_W-1:0] cnt_q;
    always_ff @(posedge clk) begin
      if (rst || clear) begin
        cnt_q <= '0;
      end else if (accept && sample_class == CLASS_W'(k) && cnt_q != CNT_MAX) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
    assign class_counts[k*CNT_W +: CNT_W] = cnt_q;
  end

  assign sample_total = total_q;
  assign run_done     = run_closed;
endmodule

// File: rtl/diag_fault_classifier.sv
module diag_fault_classifier #(
  parameter int GRID  = 4,
  parameter int CNT_W = 10
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               sample_valid,
  input  logic [8*GRID*GRID-1:0]             ref_state,
  input  logic [8*GRID*GRID-1:0]             obs_state,
  input  logic                               clear,
  input  logic [CNT_W-1:0]                   run_len,
  output logic                               result_valid,
  output logic [GRID-1:0]                    diag_mask,
  output logic [$clog2(GRID+1)-1:0]          fault_class,
  output logic [(GRID+1)*CNT_W-1:0]          class_counts,
  output logic [CNT_W-1:0]                   sample_total,
  output logic                               run_done
);
  localparam int NCLS    = GRID + 1;
  localparam int CLASS_W = $clog2(NCLS);

  logic [GRID-1:0]    mask_c;
  logic [CLASS_W-1:0] class_c;

  dfc_diag_detect #(.GRID(GRID)) u_detect (
    .ref_state (ref_state),
    .obs_state (obs_state),
    .diag_mask (mask_c)
  );

  dfc_class_encode #(.GRID(GRID), .CLASS_W(CLASS_W)) u_encode (
    .diag_mask   (mask_c),
    .fault_class (class_c)
  );

  dfc_event_counters #(.NUM_CLASSES(NCLS), .CLASS_W(CLASS_W), .CNT_W(CNT_W)) u_counters (
    .clk          (clk),
    .rst          (rst),
    .clear        (clear),
    .sample_valid (sample_valid),
    .sample_class (class_c),
    .run_len      (run_len),
    .class_counts (class_counts),
    .sample_total (sample_total),
    .run_done     (run_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result_valid <= 1'b0;
      diag_mask    <= '0;
      fault_class  <= '0;
    end else begin
      result_valid <= sample_valid;
      if (sample_valid) begin
        diag_mask   <= mask_c;
        fault_class <= class_c;
      end
    end
  end
endmodule

// File: rtl/dfc_checker.sv
module dfc_checker #(
  parameter int GRID  = 4,
  parameter int CNT_W = 10
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       sample_valid,
  input logic [8*GRID*GRID-1:0]     ref_state,
  input logic [8*GRID*GRID-1:0]     obs_state,
  input logic                       clear,
  input logic [CNT_W-1:0]           run_len,
  input logic                       result_valid,
  input logic [GRID-1:0]            diag_mask,
  input logic [$clog2(GRID+1)-1:0]  fault_class,
  input logic [(GRID+1)*CNT_W-1:0]  class_counts,
  input logic [CNT_W-1:0]           sample_total,
  input logic                       run_done
);
  localparam int NCLS    = GRID + 1;
  localparam int BYTES   = GRID * GRID;
  localparam int CLASS_W = $clog2(NCLS);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  int  diff_bytes;
  int  count_sum;
  logic any_sat;

  always_comb begin
    diff_bytes = 0;
    for (int k = 0; k < BYTES; k++) begin
      if (ref_state[8*k +: 8] != obs_state[8*k +: 8]) diff_bytes = diff_bytes + 1;
    end
  end

  always_comb begin
    count_sum = 0;
    any_sat   = 1'b0;
    for (int k = 0; k < NCLS; k++) begin
      count_sum = count_sum + int'(class_counts[k*CNT_W +: CNT_W]);
      if (class_counts[k*CNT_W +: CNT_W] == CNT_MAX) any_sat = 1'b1;
    end
  end

  assert_clean_sample_R1: assert property (@(posedge clk) disable iff (rst)
    (sample_valid && ref_state == obs_state) |=> (diag_mask == '0));

  assert_class_popcount_R2: assert property (@(posedge clk) disable iff (rst)
    result_valid |-> (int'(fault_class) == $countones(diag_mask)));

  assert_valid_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    sample_valid |=> result_valid);

  assert_valid_idle_R3: assert property (@(posedge clk) disable iff (rst)
    !sample_valid |=> (!result_valid && $stable(diag_mask) && $stable(fault_class)));

  assert_sum_matches_R5: assert property (@(posedge clk) disable iff (rst)
    (run_len != '0 && !any_sat) |-> (count_sum == int'(sample_total)));

  assert_closed_run_R6: assert property (@(posedge clk) disable iff (rst)
    (run_done && !clear) |=> $stable(sample_total));

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
    (sample_total == CNT_MAX && !clear) |=> (sample_total == CNT_MAX));

  assert_clear_zero_R8: assert property (@(posedge clk) disable iff (rst)
    clear |=> (sample_total == '0 && class_counts == '0));

  assert_small_fault_R9: assert property (@(posedge clk) disable iff (rst)
    (sample_valid && diff_bytes <= 3) |=> (fault_class != CLASS_W'(GRID)));
endmodule

bind diag_fault_classifier dfc_checker #(.GRID(GRID), .CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .sample_valid (sample_valid),
  .ref_state    (ref_state),
  .obs_state    (obs_state),
  .clear        (clear),
  .run_len      (run_len),
  .result_valid (result_valid),
  .diag_mask    (diag_mask),
  .fault_class  (fault_class),
  .class_counts (class_counts),
  .sample_total (sample_total),
  .run_done     (run_done)
);

// File: tb/diag_fault_classifier_tb.sv
module diag_fault_classifier_tb;
  localparam int CNT_W = 10;
  localparam int NCLS  = 5;
  localparam int NV    = 10;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic         rst, sample_valid, clear;
  logic [127:0] ref_s, obs_s;
  logic [9:0]   run_len;
  logic         result_valid, run_done;
  logic [3:0]   diag_mask;
  logic [2:0]   fault_class;
  logic [49:0]  class_counts;
  logic [9:0]   sample_total;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;
  int exp_cnt [NCLS];

  diag_fault_classifier u_dut (
    .clk(clk), .rst(rst), .sample_valid(sample_valid), .ref_state(ref_s),
    .obs_state(obs_s), .clear(clear), .run_len(run_len),
    .result_valid(result_valid), .diag_mask(diag_mask), .fault_class(fault_class),
    .class_counts(class_counts), .sample_total(sample_total), .run_done(run_done)
  );

  function automatic logic [127:0] fb(int r, int c, logic [7:0] v);
    return 128'(v) << (8 * (4 * c + r));
  endfunction

  localparam logic [127:0] FLIP [NV] = '{
    128'h0,
    fb(0,0,8'h01),
    fb(1,1,8'h80) | fb(3,3,8'hff),
    fb(3,0,8'h11),
    fb(0,2,8'h05) | fb(2,0,8'h07),
    fb(1,0,8'h01) | fb(0,0,8'h01),
    fb(0,1,8'h02) | fb(0,2,8'h40) | fb(0,3,8'h08),
    fb(0,0,8'h10) | fb(1,2,8'h20) | fb(2,0,8'h03) | fb(3,2,8'h04),
    {128{1'b1}},
    fb(2,3,8'h40) | fb(1,3,8'h01)
  };
  localparam logic [3:0] EXP_MASK [NV] = '{
    4'b0000, 4'b0001, 4'b0001, 4'b0010, 4'b0100,
    4'b1001, 4'b1110, 4'b1111, 4'b1111, 4'b0110
  };
  localparam logic [2:0] EXP_CLS [NV] = '{
    3'd0, 3'd1, 3'd1, 3'd1, 3'd1, 3'd2, 3'd3, 3'd4, 3'd4, 3'd2
  };

  function automatic int cnt_of(int k);
    return int'(class_counts[k*CNT_W +: CNT_W]);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic send(input logic [127:0] a, input logic [127:0] b);
    @(negedge clk);
    ref_s = a; obs_s = b; sample_valid = 1'b1;
    @(negedge clk);
    sample_valid = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [127:0] base;
    rst = 1'b1; sample_valid = 1'b0; clear = 1'b0; ref_s = '0; obs_s = '0; run_len = 10'd512;
    for (int k = 0; k < NCLS; k++) exp_cnt[k] = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R4: reset state
    check(result_valid == 1'b0, "R4", "result_valid", result_valid, 0);
    check(diag_mask == 4'd0, "R4", "diag_mask", diag_mask, 0);
    check(fault_class == 3'd0, "R4", "fault_class", fault_class, 0);
    check(class_counts == '0, "R4", "class_counts", class_counts, 0);
    check(sample_total == 10'd0, "R4", "sample_total", sample_total, 0);
    check(run_done == 1'b0, "R4", "run_done", run_done, 0);

    // R1 R2 R3: table of fault patterns
    for (int i = 0; i < NV; i++) begin
      base = {4{32'(i + 1) * 32'h9e3779b9}};
      send(base, base ^ FLIP[i]);
      check(result_valid == 1'b1, "R3", "result_valid", result_valid, 1);
      check(diag_mask == EXP_MASK[i], "R1", "diag_mask", diag_mask, EXP_MASK[i]);
      check(fault_class == EXP_CLS[i], "R2", "fault_class", fault_class, EXP_CLS[i]);
      exp_cnt[EXP_CLS[i]]++;
    end

    // R9: three faulty bytes on three diagonals
    base = 128'h0123456789abcdef_fedcba9876543210;
    send(base, base ^ (fb(1,0,8'h01) | fb(1,1,8'h02) | fb(1,2,8'h04)));
    check(fault_class != 3'd4, "R9", "fault_class not 4", fault_class, 3);
    check(diag_mask == 4'b1011, "R9", "diag_mask", diag_mask, 4'b1011);
    exp_cnt[3]++;

    // R3: hold while idle
    @(negedge clk);
    check(result_valid == 1'b0, "R3", "idle result_valid", result_valid, 0);
    check(diag_mask == 4'b1011, "R3", "idle mask held", diag_mask, 4'b1011);

    // R5: per-class counts and total
    for (int k = 0; k < NCLS; k++)
      check(cnt_of(k) == exp_cnt[k], "R5", $sformatf("count class %0d", k), cnt_of(k), exp_cnt[k]);
    check(sample_total == 10'(NV + 1), "R5", "sample_total", sample_total, NV + 1);

    // R8: clear
    @(negedge clk); clear = 1'b1;
    @(negedge clk); clear = 1'b0;
    check(class_counts == '0, "R8", "counts after clear", class_counts, 0);
    check(sample_total == 10'd0, "R8", "total after clear", sample_total, 0);
    check(diag_mask == 4'b1011, "R8", "mask kept by clear", diag_mask, 4'b1011);

    // R8: clear beats a same-cycle sample, sample still classified
    @(negedge clk);
    clear = 1'b1; ref_s = base; obs_s = base ^ fb(0,2,8'h80); sample_valid = 1'b1;
    @(negedge clk);
    clear = 1'b0; sample_valid = 1'b0;
    check(sample_total == 10'd0, "R8", "total with sample+clear", sample_total, 0);
    check(diag_mask == 4'b0100, "R8", "mask with sample+clear", diag_mask, 4'b0100);

    // R6: run closes at run_len
    @(negedge clk); clear = 1'b1; run_len = 10'd20;
    @(negedge clk); clear = 1'b0;
    for (int n = 0; n < 19; n++) send(base, base ^ fb(2,2,8'h01));
    check(run_done == 1'b0, "R6", "run_done before limit", run_done, 0);
    check(sample_total == 10'd19, "R6", "total before limit", sample_total, 19);
    send(base, base ^ fb(2,2,8'h01));
    check(run_done == 1'b1, "R6", "run_done at limit", run_done, 1);
    for (int n = 0; n < 5; n++) send(base, base ^ (fb(0,3,8'h01) | fb(0,1,8'h01)));
    check(sample_total == 10'd20, "R6", "total after limit", sample_total, 20);
    check(cnt_of(1) == 20, "R6", "class 1 count", cnt_of(1), 20);
    check(cnt_of(2) == 0, "R6", "class 2 not counted", cnt_of(2), 0);
    check(fault_class == 3'd2, "R6", "classified after limit", fault_class, 2);

    // R7: unbounded run saturates
    @(negedge clk); clear = 1'b1; run_len = 10'd0;
    @(negedge clk); clear = 1'b0;
    ref_s = base; obs_s = base; sample_valid = 1'b1;
    repeat (1030) @(negedge clk);
    sample_valid = 1'b0;
    @(negedge clk);
    check(sample_total == 10'd1023, "R7", "saturated total", sample_total, 1023);
    check(cnt_of(0) == 1023, "R7", "saturated class 0", cnt_of(0), 1023);
    check(run_done == 1'b0, "R7", "run_done unbounded", run_done, 0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule